// File: doc/BRIEF.md
# ATAPI PIO Burst Transfer Engine

This block moves the data belonging to a single device interrupt between a host byte stream and a 16-bit device data port. When it is started, it samples the byte count the device is asking for from two 8-bit count registers, along with the host's remaining residual and the transfer direction. It then moves the smaller of the two quantities. Whole 16-bit words go first. A trailing odd byte is handled inside one final word access.

On an inbound burst, bytes from the device go out on a valid/ready stream, low byte of each word first. Any words the device still offers beyond the kept bytes are read and thrown away. On an outbound burst, bytes from a valid/ready input stream are packed little-endian into words and written to the device. A last lone byte is widened with zeros.

After the last access the engine waits a settle time given in nanoseconds. It then pulses `done` and presents the reduced residual. A sticky flag records that a data burst has been started since reset. Choosing the phase and issuing commands are handled elsewhere.

Top module: `pio_burst_engine`

## Requirements
- R1: On an accepted `start`, the device byte count is taken as `dev_cnt_hi` times 256 plus `dev_cnt_lo`. Later changes to those inputs have no effect on the burst in progress.
- R2: The number of bytes handed to or taken from the host equals the smaller of `host_resid` and the device byte count.
- R3: Data is moved as whole 16-bit words first. Each word pairs two consecutive host bytes little-endian: the earlier byte sits in bits 7:0, the later one in bits 15:8. An outbound burst issues exactly ceil(kept/2) word writes.
- R4: When an inbound burst keeps an odd number of bytes, the last kept byte is bits 7:0 of one full word read from the device. Bits 15:8 of that word never appear on the host stream.
- R5: When an outbound burst keeps an odd number of bytes, the last word written is the final byte in bits 7:0 and zero in bits 15:8.
- R6: An inbound burst reads exactly ceil(device count/2) words from the device. Words beyond the kept bytes are discarded without any host stream output.
- R7: When `done` is high, `resid_left` equals `host_resid` minus the kept byte count. `resid_left` changes only in a cycle in which `done` is high.
- R8: `moved` is 0 after reset, goes to 1 on the first accepted `start`, and stays 1 until reset.
- R9: `done` is a one-cycle pulse. It comes SETTLE_CYC+1 cycles after the cycle of the last start, device access or host handshake of the burst, where SETTLE_CYC = ceil(SETTLE_NS/CLK_NS).
- R10: A stalled handshake loses nothing. `hs_out_valid` stays high with unchanged `hs_out_data` until `hs_out_ready`, and input bytes are consumed only when `hs_in_valid` and `hs_in_ready` are both high.
- R11: `start` while `busy` is ignored. Outside a burst, no device strobe, `hs_out_valid` or `hs_in_ready` is asserted.
- R12: In reset, `busy`, `done`, `moved`, both device strobes, `hs_out_valid` and `hs_in_ready` are 0, and `resid_left` is 0.
- R13: An inbound burst (`dir_in`=1) never asserts `dev_wr_stb` or `hs_in_ready`. An outbound burst (`dir_in`=0) never asserts `dev_rd_stb` or `hs_out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one burst (accepted only when idle) |
| dir_in | input | 1 | 1 = device to host, 0 = host to device |
| dev_cnt_hi | input | 8 | Device byte count, upper byte |
| dev_cnt_lo | input | 8 | Device byte count, lower byte |
| host_resid | input | RESID_W | Host bytes still outstanding |
| busy | output | 1 | Burst or settle in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| resid_left | output | RESID_W | Residual after the last burst |
| moved | output | 1 | Sticky data-burst flag |
| dev_rd_stb | output | 1 | Read one word from the device port this cycle |
| dev_rdata | input | 16 | Device word, sampled while `dev_rd_stb` is high |
| dev_wr_stb | output | 1 | Write one word to the device port this cycle |
| dev_wdata | output | 16 | Word written while `dev_wr_stb` is high |
| hs_out_valid | output | 1 | Inbound byte available to host |
| hs_out_ready | input | 1 | Host accepts inbound byte |
| hs_out_data | output | 8 | Inbound byte |
| hs_in_valid | input | 1 | Outbound byte offered by host |
| hs_in_ready | output | 1 | Engine accepts outbound byte |
| hs_in_data | input | 8 | Outbound byte |

## Verification
The bench targets the following corner cases:
- Odd kept counts in both directions. A design that drops the half-word path would either leak the discarded high byte to the host or write a stale upper byte instead of zero.
- A residual of zero, and a residual smaller than an odd device count. A wrong minimum or a wrong drain count shows up as an extra host byte or as a device read total that differs from ceil(count/2).
- A device count above 255 and count registers that change after `start`. Mishandling the high byte or sampling the registers late changes the number of reads.
- Stalling handshakes, a `start` pulsed mid-burst, and settle timing measured from the last access. These catch lost bytes, restarted bursts and an off-by-one settle delay.

// File: rtl/pio_burst_pkg.sv
`timescale 1ns/1ps
package pio_burst_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EMIT,
        ST_DRAIN,
        ST_GATHER,
        ST_PUT,
        ST_SETTLE
    } eng_state_e;

    typedef struct packed {
        cnt_t dev_bytes;
        cnt_t keep_bytes;
        cnt_t keep_words;
        cnt_t drain_words;
    } burst_plan_t;

    // Number of 16-bit words needed to carry n bytes.
    function automatic cnt_t half_up(cnt_t n);
        logic [CNT_W:0] t;
        t = {1'b0, n} + {{CNT_W{1'b0}}, 1'b1};
        return t[CNT_W:1];
    endfunction

endpackage

// File: rtl/pio_burst_plan.sv
`timescale 1ns/1ps
module pio_burst_plan
    import pio_burst_pkg::*;
#(
    parameter int RESID_W = 24
) (
    input  logic [BYTE_W-1:0]  cnt_hi,
    input  logic [BYTE_W-1:0]  cnt_lo,
    input  logic [RESID_W-1:0] resid,
    output burst_plan_t        plan
);

    localparam int CMP_W = (RESID_W > CNT_W) ? RESID_W : CNT_W;

    cnt_t             dev_bytes;
    cnt_t             keep_bytes;
    logic [CMP_W-1:0] resid_ext;
    logic [CMP_W-1:0] dev_ext;

    always_comb begin
        dev_bytes = {cnt_hi, cnt_lo};
        resid_ext = CMP_W'(resid);
        dev_ext   = CMP_W'(dev_bytes);
        keep_bytes = (resid_ext < dev_ext) ? CNT_W'(resid_ext) : dev_bytes;

        plan.dev_bytes   = dev_bytes;
        plan.keep_bytes  = keep_bytes;
        plan.keep_words  = half_up(keep_bytes);
        // Kept words never exceed the device's rounded-up word count.
        plan.drain_words = half_up(dev_bytes) - half_up(keep_bytes);
    end

endmodule

// File: rtl/pio_settle_timer.sv
`timescale 1ns/1ps
module pio_settle_timer #(
    parameter int CLK_NS    = 10,
    parameter int SETTLE_NS = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);

    localparam int CYC_RAW = (SETTLE_NS + CLK_NS - 1) / CLK_NS;
    localparam int CYC     = (CYC_RAW < 1) ? 1 : CYC_RAW;
    localparam int CW      = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    assign last = run && (cnt_q == CW'(CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pio_word_lane.sv
`timescale 1ns/1ps
module pio_word_lane
    import pio_burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_word,
    input  word_t word_in,
    input  logic  wr_lo,
    input  logic  wr_hi,
    input  byte_t byte_in,
    input  logic  sel_hi,
    output word_t word_out,
    output byte_t byte_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit IS_LOW = (g == 0);
        byte_t lane_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (ld_word) begin
                lane_q <= word_in[g*BYTE_W +: BYTE_W];
            end else if (IS_LOW ? wr_lo : wr_hi) begin
                lane_q <= byte_in;
            end else if (!IS_LOW && wr_lo) begin
                // A fresh low byte zero-fills the upper half.
                lane_q <= '0;
            end
        end

        assign word_out[g*BYTE_W +: BYTE_W] = lane_q;
    end

    assign byte_out = sel_hi ? word_out[WORD_W-1:BYTE_W] : word_out[BYTE_W-1:0];

endmodule

// File: rtl/pio_burst_engine.sv
`timescale 1ns/1ps
module pio_burst_engine
    import pio_burst_pkg::*;
#(
    parameter int RESID_W   = 24,
    parameter int CLK_NS    = 10,
    parameter int SETTLE_NS = 400
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               dir_in,
    input  logic [7:0]         dev_cnt_hi,
    input  logic [7:0]         dev_cnt_lo,
    input  logic [RESID_W-1:0] host_resid,
    output logic               busy,
    output logic               done,
    output logic [RESID_W-1:0] resid_left,
    output logic               moved,
    output logic               dev_rd_stb,
    input  logic [15:0]        dev_rdata,
    output logic               dev_wr_stb,
    output logic [15:0]        dev_wdata,
    output logic               hs_out_valid,
    input  logic               hs_out_ready,
    output logic [7:0]         hs_out_data,
    input  logic               hs_in_valid,
    output logic               hs_in_ready,
    input  logic [7:0]         hs_in_data
);

    eng_state_e         st_q;
    cnt_t               bytes_q;
    cnt_t               drain_q;
    logic               hi_q;
    logic               rd_dir_q;
    logic               done_q;
    logic               moved_q;
    logic [RESID_W-1:0] resid_q;
    logic [RESID_W-1:0] resid_pend_q;

    burst_plan_t plan;
    logic        settle_last;
    logic        wr_lo;
    logic        wr_hi;
    word_t       lane_word;
    byte_t       lane_byte;
    logic        last_byte;
    logic        start_go;

    pio_burst_plan #(.RESID_W(RESID_W)) u_plan (
        .cnt_hi (dev_cnt_hi),
        .cnt_lo (dev_cnt_lo),
        .resid  (host_resid),
        .plan   (plan)
    );

    pio_settle_timer #(.CLK_NS(CLK_NS), .SETTLE_NS(SETTLE_NS)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .run  (st_q == ST_SETTLE),
        .last (settle_last)
    );

    assign wr_lo = (st_q == ST_GATHER) && hs_in_valid && !hi_q;
    assign wr_hi = (st_q == ST_GATHER) && hs_in_valid && hi_q;

    pio_word_lane u_lane (
        .clk      (clk),
        .rst      (rst),
        .ld_word  (st_q == ST_FETCH),
        .word_in  (dev_rdata),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .byte_in  (hs_in_data),
        .sel_hi   (hi_q),
        .word_out (lane_word),
        .byte_out (lane_byte)
    );

    assign last_byte = (bytes_q == cnt_t'(1));
    assign start_go  = start && (st_q == ST_IDLE);

    assign busy         = (st_q != ST_IDLE);
    assign done         = done_q;
    assign moved        = moved_q;
    assign resid_left   = resid_q;
    assign dev_rd_stb   = (st_q == ST_FETCH) || (st_q == ST_DRAIN);
    assign dev_wr_stb   = (st_q == ST_PUT);
    assign dev_wdata    = lane_word;
    assign hs_out_valid = (st_q == ST_EMIT);
    assign hs_out_data  = lane_byte;
    assign hs_in_ready  = (st_q == ST_GATHER);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            bytes_q      <= '0;
            drain_q      <= '0;
            hi_q         <= 1'b0;
            rd_dir_q     <= 1'b0;
            done_q       <= 1'b0;
            moved_q      <= 1'b0;
            resid_q      <= '0;
            resid_pend_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_go) begin
                        moved_q      <= 1'b1;
                        rd_dir_q     <= dir_in;
                        hi_q         <= 1'b0;
                        bytes_q      <= plan.keep_bytes;
                        drain_q      <= plan.drain_words;
                        resid_pend_q <= host_resid - RESID_W'(plan.keep_bytes);
                        if (dir_in) begin
                            if (plan.keep_bytes != '0)       st_q <= ST_FETCH;
                            else if (plan.drain_words != '0) st_q <= ST_DRAIN;
                            else                             st_q <= ST_SETTLE;
                        end else begin
                            st_q <= (plan.keep_bytes != '0) ? ST_GATHER : ST_SETTLE;
                        end
                    end
                end
                ST_FETCH: begin
                    hi_q <= 1'b0;
                    st_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (hs_out_ready) begin
                        bytes_q <= bytes_q - 1'b1;
                        if (last_byte) begin
                            hi_q <= 1'b0;
                            st_q <= (drain_q != '0) ? ST_DRAIN : ST_SETTLE;
                        end else if (hi_q) begin
                            hi_q <= 1'b0;
                            st_q <= ST_FETCH;
                        end else begin
                            hi_q <= 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    drain_q <= drain_q - 1'b1;
                    if (drain_q == cnt_t'(1)) st_q <= ST_SETTLE;
                end
                ST_GATHER: begin
                    if (hs_in_valid) begin
                        bytes_q <= bytes_q - 1'b1;
                        if (hi_q) begin
                            hi_q <= 1'b0;
                            st_q <= ST_PUT;
                        end else if (last_byte) begin
                            st_q <= ST_PUT;
                        end else begin
                            hi_q <= 1'b1;
                        end
                    end
                end
                ST_PUT: begin
                    st_q <= (bytes_q == '0) ? ST_SETTLE : ST_GATHER;
                end
                ST_SETTLE: begin
                    if (settle_last) begin
                        st_q    <= ST_IDLE;
                        done_q  <= 1'b1;
                        resid_q <= resid_pend_q;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pio_burst_checks.sv
`timescale 1ns/1ps
module pio_burst_checks #(
    parameter int RESID_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               moved,
    input logic [RESID_W-1:0] resid_left,
    input logic               dev_rd_stb,
    input logic               dev_wr_stb,
    input logic               hs_out_valid,
    input logic               hs_out_ready,
    input logic [7:0]         hs_out_data,
    input logic               hs_in_ready,
    input logic               rd_dir
);

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (hs_out_valid && !hs_out_ready) |=> (hs_out_valid && $stable(hs_out_data)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_resid_moves_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(resid_left) |-> done);

    assert_moved_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        moved |=> moved);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(dev_rd_stb || dev_wr_stb || hs_out_valid || hs_in_ready));

    assert_write_side_only_out_R13: assert property (@(posedge clk) disable iff (rst)
        (dev_wr_stb || hs_in_ready) |-> !rd_dir);

    assert_read_side_only_in_R13: assert property (@(posedge clk) disable iff (rst)
        (dev_rd_stb || hs_out_valid) |-> rd_dir);

endmodule

bind pio_burst_engine pio_burst_checks #(.RESID_W(RESID_W)) u_checks (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .moved        (moved),
    .resid_left   (resid_left),
    .dev_rd_stb   (dev_rd_stb),
    .dev_wr_stb   (dev_wr_stb),
    .hs_out_valid (hs_out_valid),
    .hs_out_ready (hs_out_ready),
    .hs_out_data  (hs_out_data),
    .hs_in_ready  (hs_in_ready),
    .rd_dir       (rd_dir_q)
);

// File: tb/pio_burst_engine_tb.sv
`timescale 1ns/1ps
module pio_burst_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE_NS  = 400;
    localparam int RESID_W    = 24;
    localparam int GAP        = (SETTLE_NS + CLK_PERIOD - 1) / CLK_PERIOD + 1;
    localparam int WATCHDOG   = 150000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic               dir_in = 1'b0;
    logic [7:0]         dev_cnt_hi = '0;
    logic [7:0]         dev_cnt_lo = '0;
    logic [RESID_W-1:0] host_resid = '0;
    logic               busy, done, moved;
    logic [RESID_W-1:0] resid_left;
    logic               dev_rd_stb, dev_wr_stb;
    logic [15:0]        dev_rdata = '0;
    logic [15:0]        dev_wdata;
    logic               hs_out_valid;
    logic               hs_out_ready = 1'b0;
    logic [7:0]         hs_out_data;
    logic               hs_in_valid = 1'b0;
    logic               hs_in_ready;
    logic [7:0]         hs_in_data = '0;

    pio_burst_engine #(.RESID_W(RESID_W), .CLK_NS(CLK_PERIOD), .SETTLE_NS(SETTLE_NS)) u_dut (
        .clk(clk), .rst(rst), .start(start), .dir_in(dir_in),
        .dev_cnt_hi(dev_cnt_hi), .dev_cnt_lo(dev_cnt_lo), .host_resid(host_resid),
        .busy(busy), .done(done), .resid_left(resid_left), .moved(moved),
        .dev_rd_stb(dev_rd_stb), .dev_rdata(dev_rdata),
        .dev_wr_stb(dev_wr_stb), .dev_wdata(dev_wdata),
        .hs_out_valid(hs_out_valid), .hs_out_ready(hs_out_ready), .hs_out_data(hs_out_data),
        .hs_in_valid(hs_in_valid), .hs_in_ready(hs_in_ready), .hs_in_data(hs_in_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference model state
    bit          stall = 0;
    bit          cur_rd = 0;
    bit          odd_out = 0;
    logic [7:0]  exp_bytes[$];
    logic [15:0] exp_words[$];
    logic [7:0]  src_q[$];
    int          rd_idx = 0;
    int          wr_cnt = 0;
    int          last_act = 0;
    int          salt = 0;
    int          keep_n = 0;
    bit          done_seen = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] dev_word(int i);
        return {8'(salt * 11 + 2 * i + 1), 8'(salt * 3 + 5 * i + 7)};
    endfunction

    function automatic logic [7:0] host_byte(int j);
        return 8'(salt * 13 + 7 * j + 129);
    endfunction

    // Per-clock model: device port, host streams, settle timing
    always @(negedge clk) begin
        if (!rst) begin
            dev_rdata = dev_word(rd_idx);
            if (dev_rd_stb) begin
                rd_idx++;
                last_act = cyc;
                check(cur_rd, "R13 read strobe on outbound burst", 0, 1);
            end
            if (dev_wr_stb) begin
                logic [15:0] w;
                wr_cnt++;
                last_act = cyc;
                if (exp_words.size() == 0) begin
                    check(0, "R3 extra device word write", dev_wdata, 0);
                end else begin
                    w = exp_words.pop_front();
                    if (exp_words.size() == 0 && odd_out)
                        check(dev_wdata == w, "R5 odd last word zero-extended", dev_wdata, w);
                    else
                        check(dev_wdata == w, "R3 packed word little-endian", dev_wdata, w);
                end
            end
            hs_out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (hs_out_valid && hs_out_ready) begin
                logic [7:0] b;
                last_act = cyc;
                if (exp_bytes.size() == 0) begin
                    check(0, "R6 surplus byte reached host", hs_out_data, 0);
                end else begin
                    b = exp_bytes.pop_front();
                    check(hs_out_data == b, "R4 inbound byte value", hs_out_data, b);
                end
            end
            if (hs_in_ready && cur_rd) check(0, "R13 input ready on inbound burst", 1, 0);
            hs_in_valid = (src_q.size() > 0) && (!stall || (cyc % 2) == 0);
            hs_in_data  = hs_in_valid ? src_q[0] : 8'h00;
            if (hs_in_valid && hs_in_ready) begin
                void'(src_q.pop_front());
                last_act = cyc;
            end
            if (done) begin
                done_seen = 1;
                check((cyc - last_act) == GAP, "R9 settle delay", cyc - last_act, GAP);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_burst(input bit rd, input int cnt, input int resid, input bit stall_mode, input bit poke);
        int kw;
        salt++;
        cur_rd = rd;
        stall = stall_mode;
        exp_bytes.delete();
        exp_words.delete();
        src_q.delete();
        rd_idx = 0;
        wr_cnt = 0;
        done_seen = 0;
        keep_n = (resid < cnt) ? resid : cnt;
        kw = (keep_n + 1) / 2;
        odd_out = !rd && (keep_n % 2 == 1);
        if (rd) begin
            for (int i = 0; i < keep_n; i++) begin
                logic [15:0] w;
                w = dev_word(i / 2);
                exp_bytes.push_back((i % 2) ? w[15:8] : w[7:0]);
            end
        end else begin
            for (int j = 0; j < keep_n; j++) src_q.push_back(host_byte(j));
            for (int k = 0; k < kw; k++) begin
                logic [7:0] lo, hi;
                lo = host_byte(2 * k);
                hi = (2 * k + 1 < keep_n) ? host_byte(2 * k + 1) : 8'h00;
                exp_words.push_back({hi, lo});
            end
        end
        @(negedge clk);
        start = 1'b1;
        dir_in = rd;
        dev_cnt_hi = 8'(cnt >> 8);
        dev_cnt_lo = 8'(cnt);
        host_resid = RESID_W'(resid);
        last_act = cyc;
        @(negedge clk);
        start = 1'b0;
        // R1: count registers change after start and must not matter
        dev_cnt_hi = 8'hFF;
        dev_cnt_lo = 8'hFF;
        host_resid = '1;
        if (poke) begin
            repeat (2) @(negedge clk);
            check(busy, "R11 busy before mid-burst start", busy, 1);
            start = 1'b1;
            dir_in = !rd;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 6000; t++) begin
            @(negedge clk);
            #1;
            if (done_seen) break;
        end
        check(done_seen, "R9 done reached", done_seen, 1);
        check(resid_left == RESID_W'(resid - keep_n), "R7 residual", resid_left, resid - keep_n);
        check(rd_idx == (rd ? (cnt + 1) / 2 : 0), "R6 device read count / R1 count", rd_idx, rd ? (cnt + 1) / 2 : 0);
        check(wr_cnt == (rd ? 0 : kw), "R3 device write count", wr_cnt, rd ? 0 : kw);
        check(exp_bytes.size() == 0, "R2 host bytes delivered", exp_bytes.size(), 0);
        check(src_q.size() == 0, "R2 host bytes consumed", src_q.size(), 0);
        check(moved, "R8 moved flag set", moved, 1);
        @(negedge clk);
        #1;
        check(!done, "R9 done single cycle", done, 0);
        check(!busy, "R11 idle after burst", busy, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !moved, "R12 reset flags", {busy, done, moved}, 0);
        check(!dev_rd_stb && !dev_wr_stb && !hs_out_valid && !hs_in_ready, "R12 reset strobes", 1, 0);
        check(resid_left == '0, "R12 reset residual", resid_left, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!moved, "R8 moved clear before first start", moved, 0);

        run_burst(1, 8,   100, 0, 0);  // even, no drain
        run_burst(1, 7,   100, 0, 0);  // R4 odd inbound, no drain
        run_burst(1, 20,  5,   1, 0);  // R4 odd kept with drain, stalled sink
        run_burst(1, 258, 300, 1, 0);  // R1 high count byte
        run_burst(1, 259, 3,   0, 0);  // R1/R6 odd device count, heavy drain
        run_burst(1, 6,   0,   0, 0);  // R6 drain only
        run_burst(1, 0,   40,  0, 0);  // nothing to move
        run_burst(0, 6,   50,  0, 0);  // even outbound
        run_burst(0, 9,   50,  1, 0);  // R5 odd outbound, stalled source
        run_burst(0, 300, 11,  0, 0);  // R5 residual limits, odd
        run_burst(0, 4,   0,   0, 0);  // zero residual outbound
        run_burst(1, 40,  30,  1, 1);  // R11 start while busy
        run_burst(0, 13,  13,  1, 1);  // R11 start while busy, outbound
        check(moved, "R8 moved stays set", moved, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule